// File: doc/BRIEF.md
# Framebuffer Pixel Store Repacker

This block turns one drawing-side pixel and its raster position into a single write on a 32-bit memory port. The drawing side works with a wide pixel of four 16-bit channels. The framebuffer holds one of three narrower storage formats. The block finds the row without a general multiplier: each row is one of six fixed line pitches, and rows are padded up to the next pitch in the table. For example, a 320-pixel-wide screen uses a 384-pixel pitch, and a 640-pixel-wide screen uses a 768-pixel pitch. Each pitch is the sum of at most two shifted copies of the row number.

Each accepted pixel gives one registered write a cycle later. The write carries a byte address, a 32-bit data word and byte enables. The framebuffer base, the pitch code and the storage format are configuration inputs, and they are applied together with each pixel.

Top module: `fb_pixel_store`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_valid` becomes 0 and `wr_addr`, `wr_data` and `wr_be` become 0.
- R2: `wr_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R3: Pitch codes 0, 1, 2, 3, 4 and 5 select row pitches of 256, 384, 512, 768, 1024 and 1536 pixels.
- R4: Pitch codes 6 and 7 select a pitch of 256 pixels.
- R5: `wr_addr` = `cfg_base` + (y*pitch + x) * bpp, modulo 2^32. bpp is 4 for format codes 0 and 3, and 2 for format codes 1 and 2.
- R6: Format code 0 (32-bit) writes data = {R[15:8], G[15:8], B[15:8], A[15:8]}. The input pixel is laid out as A in bits 63:48, R in bits 47:32, G in bits 31:16 and B in bits 15:0.
- R7: Format code 1 (15-bit colour) writes the 16-bit value {0, R[15:11], G[15:11], B[15:11]}. Bit 15 of that value is always 0.
- R8: Format code 2 (four bits per channel) writes the 16-bit value {R[15:12], G[15:12], B[15:12], A[15:12]}.
- R9: For 32-bit formats, `wr_be` = 4'b1111. For 16-bit formats, the 16-bit value is repeated in both halves of `wr_data`, and `wr_be` is 4'b0011 when `wr_addr[1]` is 0 and 4'b1100 when it is 1.
- R10: Format code 3 behaves exactly like format code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_x | input | 12 | Column of the pixel |
| in_y | input | 12 | Row of the pixel |
| in_pixel | input | 64 | Wide pixel: A, R, G, B channels of 16 bits, A at the top |
| cfg_base | input | 32 | Byte address of pixel (0,0), 4-byte aligned |
| cfg_stride_code | input | 3 | Row pitch select |
| cfg_fmt | input | 2 | Storage format select |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Byte address of the pixel |
| wr_data | output | 32 | Repacked write data |
| wr_be | output | 4 | Byte enables within the 32-bit word |

## Verification
The assertions assume that `cfg_base` is a multiple of four. Under that assumption, a 32-bit write lands on a word boundary, and a 16-bit write always selects exactly one of the two halves. They also assume that the configuration inputs are sampled only in cycles where `in_valid` is high. The stimulus only ever uses word-aligned bases. It changes the pitch code and format freely between pixels, and it visits every code of both. It also includes idle gaps, so the one-cycle relation between input and write is exercised in both directions.

// File: rtl/fbps_pkg.sv
// Shared types for the framebuffer pixel store repacker.
// Assumes nothing beyond a 2-bit format selector.
package fbps_pkg;
    typedef enum logic [1:0] {
        FMT_W32   = 2'd0,
        FMT_C555  = 2'd1,
        FMT_C4444 = 2'd2,
        FMT_W32B  = 2'd3
    } pix_fmt_e;

    // True when a format stores four bytes per pixel.
    function automatic logic fmt_is_wide(input pix_fmt_e f);
        return (f == FMT_W32) || (f == FMT_W32B);
    endfunction
endpackage

// File: rtl/fbps_row_offset.sv
// Row offset in pixels: y times a pitch drawn from a fixed table.
// Each pitch is one power of two, or a power of two plus its half, so the
// product is formed from at most two shifted copies of y.
// Assumes OFF_W is wide enough for y << (MIN_SH + 2) plus its half.
module fbps_row_offset #(
    parameter int Y_W    = 12,
    parameter int OFF_W  = 32,
    parameter int MIN_SH = 8
) (
    input  logic [Y_W-1:0]   y,
    input  logic [2:0]       code,
    output logic [OFF_W-1:0] row_off
);
    localparam int SH0 = MIN_SH;
    localparam int SH1 = MIN_SH + 1;
    localparam int SH2 = MIN_SH + 2;

    logic [OFF_W-1:0] yw;
    assign yw = OFF_W'(y);

    // Shift-and-add pitch product; unused codes fall back to the smallest pitch.
    always_comb begin
        unique case (code)
            3'd0:    row_off = yw << SH0;
            3'd1:    row_off = (yw << SH0) + (yw << (SH0 - 1));
            3'd2:    row_off = yw << SH1;
            3'd3:    row_off = (yw << SH1) + (yw << SH0);
            3'd4:    row_off = yw << SH2;
            3'd5:    row_off = (yw << SH2) + (yw << SH1);
            default: row_off = yw << SH0;
        endcase
    end
endmodule

// File: rtl/fbps_repack.sv
// Reduces a wide four-channel pixel to the 32-bit and 16-bit storage words.
// Keeps the top bits of each channel. Assumes CH_W >= 8.
module fbps_repack
    import fbps_pkg::*;
#(
    parameter int CH_W = 16
) (
    input  logic [4*CH_W-1:0] pixel,
    input  pix_fmt_e          fmt,
    output logic [31:0]       word32,
    output logic [15:0]       word16
);
    logic [CH_W-1:0] ch_a, ch_r, ch_g, ch_b;

    // Channel split: A highest, then R, G, B.
    always_comb begin
        ch_a = pixel[4*CH_W-1 -: CH_W];
        ch_r = pixel[3*CH_W-1 -: CH_W];
        ch_g = pixel[2*CH_W-1 -: CH_W];
        ch_b = pixel[CH_W-1   -: CH_W];
    end

    // Eight bits per channel, red in the top byte, alpha in the bottom byte.
    always_comb begin
        word32 = {ch_r[CH_W-1 -: 8], ch_g[CH_W-1 -: 8],
                  ch_b[CH_W-1 -: 8], ch_a[CH_W-1 -: 8]};
    end

    // Narrow word chosen by format: 5-5-5 with a clear top bit, or 4-4-4-4.
    always_comb begin
        if (fmt == FMT_C555)
            word16 = {1'b0, ch_r[CH_W-1 -: 5], ch_g[CH_W-1 -: 5], ch_b[CH_W-1 -: 5]};
        else
            word16 = {ch_r[CH_W-1 -: 4], ch_g[CH_W-1 -: 4],
                      ch_b[CH_W-1 -: 4], ch_a[CH_W-1 -: 4]};
    end
endmodule

// File: rtl/fbps_lane_place.sv
// Places the storage word on the 32-bit write lanes and forms byte enables.
// Assumes the byte address of a 16-bit pixel is even (base word aligned).
module fbps_lane_place (
    input  logic        wide,
    input  logic        half_sel,
    input  logic [31:0] word32,
    input  logic [15:0] word16,
    output logic [31:0] data,
    output logic [3:0]  be
);
    // Full word for wide formats; narrow word duplicated, one half enabled.
    always_comb begin
        if (wide) begin
            data = word32;
            be   = 4'b1111;
        end else begin
            data = {word16, word16};
            be   = half_sel ? 4'b1100 : 4'b0011;
        end
    end
endmodule

// File: rtl/fb_pixel_store.sv
// Framebuffer pixel store: raster position plus wide pixel in, one registered
// memory write out a cycle later. Configuration is sampled with each pixel.
// Assumes cfg_base is 4-byte aligned.
module fb_pixel_store
    import fbps_pkg::*;
#(
    parameter int X_W    = 12,
    parameter int Y_W    = 12,
    parameter int ADDR_W = 32,
    parameter int CH_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    input  logic [4*CH_W-1:0] in_pixel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [2:0]        cfg_stride_code,
    input  logic [1:0]        cfg_fmt,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be
);
    localparam int MIN_SH = 8;

    pix_fmt_e          fmt;
    logic              wide;
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] pix_idx;
    logic [ADDR_W-1:0] byte_addr;
    logic [31:0]       w32;
    logic [15:0]       w16;
    logic [31:0]       lane_data;
    logic [3:0]        lane_be;

    assign fmt  = pix_fmt_e'(cfg_fmt);
    assign wide = fmt_is_wide(fmt);

    fbps_row_offset #(.Y_W(Y_W), .OFF_W(ADDR_W), .MIN_SH(MIN_SH)) u_row (
        .y       (in_y),
        .code    (cfg_stride_code),
        .row_off (row_off)
    );

    // Pixel index and byte address; bytes per pixel is a shift of 2 or 1.
    always_comb begin
        pix_idx   = row_off + ADDR_W'(in_x);
        byte_addr = cfg_base + (wide ? (pix_idx << 2) : (pix_idx << 1));
    end

    fbps_repack #(.CH_W(CH_W)) u_pack (
        .pixel  (in_pixel),
        .fmt    (fmt),
        .word32 (w32),
        .word16 (w16)
    );

    fbps_lane_place u_lane (
        .wide     (wide),
        .half_sel (byte_addr[1]),
        .word32   (w32),
        .word16   (w16),
        .data     (lane_data),
        .be       (lane_be)
    );

    // Output register for the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_be    <= '0;
        end else begin
            wr_valid <= in_valid;
            if (in_valid) begin
                wr_addr <= byte_addr;
                wr_data <= lane_data;
                wr_be   <= lane_be;
            end
        end
    end

    // Each accepted pixel gives exactly one write a cycle later.
    assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_valid);
    // 32-bit formats enable all lanes at a word-aligned address.
    assert_wide_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cfg_fmt == 2'd0 || cfg_fmt == 2'd3)) |=>
        (wr_be == 4'b1111 && wr_addr[1:0] == 2'b00));
    // 16-bit formats enable exactly one half, chosen by address bit 1.
    assert_half_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cfg_fmt == 2'd1 || cfg_fmt == 2'd2)) |=>
        ($countones(wr_be) == 2 && wr_be[{wr_addr[1], 1'b0}] && wr_addr[0] == 1'b0));
    // The 15-bit colour format never sets the spare top bit in either half.
    assert_c555_top_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_fmt == 2'd1) |=> (wr_data[31] == 1'b0 && wr_data[15] == 1'b0));
    // Halves of a 16-bit write carry the same value.
    assert_half_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cfg_fmt == 2'd1 || cfg_fmt == 2'd2)) |=>
        (wr_data[31:16] == wr_data[15:0]));
endmodule

// File: tb/fb_pixel_store_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference computed with integer arithmetic, compared on
// every falling edge against the write registered at the preceding rising edge.
module fb_pixel_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [63:0] in_pixel = '0;
    logic [31:0] cfg_base = '0;
    logic [2:0]  cfg_stride_code = '0;
    logic [1:0]  cfg_fmt = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit          exp_valid = 0;
    logic [31:0] exp_addr, exp_data;
    logic [3:0]  exp_be;
    string       addr_tag, data_tag;

    always #2.5 clk = ~clk;

    fb_pixel_store u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_pixel(in_pixel), .cfg_base(cfg_base), .cfg_stride_code(cfg_stride_code),
        .cfg_fmt(cfg_fmt), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint pitch_of(input int code);
        case (code)
            1: return 384;
            2: return 512;
            3: return 768;
            4: return 1024;
            5: return 1536;
            default: return 256;
        endcase
    endfunction

    // Compare the outputs against the expectation left by the previous cycle.
    task automatic compare_prev();
        if (exp_valid) begin
            check("R2 valid", 32'(wr_valid), 32'd1);
            check(addr_tag, wr_addr, exp_addr);
            check(data_tag, wr_data, exp_data);
            check("R9 byte enables", 32'(wr_be), 32'(exp_be));
        end else begin
            check("R2 idle", 32'(wr_valid), 32'd0);
        end
    endtask

    task automatic send(input int x, input int y, input logic [63:0] pix,
                        input int code, input int fmt, input logic [31:0] base);
        longint idx, bpp, a;
        logic [15:0] v16;
        logic [15:0] ca, cr, cg, cb;
        @(negedge clk);
        compare_prev();
        in_valid = 1'b1; in_x = 12'(x); in_y = 12'(y); in_pixel = pix;
        cfg_stride_code = 3'(code); cfg_fmt = 2'(fmt); cfg_base = base;
        ca = pix[63:48]; cr = pix[47:32]; cg = pix[31:16]; cb = pix[15:0];
        bpp = (fmt == 1 || fmt == 2) ? 2 : 4;
        idx = longint'(y) * pitch_of(code) + longint'(x);
        a = (longint'(base) + idx * bpp) & 64'hFFFF_FFFF;
        exp_addr = 32'(a);
        addr_tag = (code >= 6) ? "R4 address" : ((bpp == 2) ? "R5 address" : "R3 address");
        if (bpp == 4) begin
            exp_data = {cr[15:8], cg[15:8], cb[15:8], ca[15:8]};
            exp_be = 4'hF;
            data_tag = (fmt == 3) ? "R10 data" : "R6 data";
        end else begin
            if (fmt == 1) begin
                v16 = {1'b0, cr[15:11], cg[15:11], cb[15:11]};
                data_tag = "R7 data";
            end else begin
                v16 = {cr[15:12], cg[15:12], cb[15:12], ca[15:12]};
                data_tag = "R8 data";
            end
            exp_data = {v16, v16};
            exp_be = exp_addr[1] ? 4'b1100 : 4'b0011;
        end
        exp_valid = 1;
    endtask

    task automatic idle();
        @(negedge clk);
        compare_prev();
        in_valid = 1'b0;
        exp_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(wr_valid), 32'd0);
        check("R1 addr", wr_addr, 32'd0);
        check("R1 data", wr_data, 32'd0);
        check("R1 be", 32'(wr_be), 32'd0);
        rst_n = 1'b1;
        idle();
        // R3/R4: every pitch code, 32-bit format
        for (int c = 0; c < 8; c++) send(5, 3, 64'hFFFF_8000_4000_0100, c, 0, 32'h1000_0000);
        // Padded screen widths: 320 -> pitch 384, 640 -> pitch 768
        send(319, 199, 64'h1234_5678_9ABC_DEF0, 1, 0, 32'h0);
        send(639, 479, 64'h1234_5678_9ABC_DEF0, 3, 2, 32'h0020_0000);
        idle();
        // R7/R8/R9: 16-bit formats, even and odd columns pick lanes
        for (int c = 0; c < 8; c++) begin
            send(c, 1, 64'hF0F0_FFFF_8421_0842, c, 1, 32'h0004_0000);
            send(c + 1, 2, 64'hA5A5_5A5A_C3C3_3C3C, c, 2, 32'h0004_0000);
        end
        idle();
        idle();
        // R10: format code 3 equals format code 0
        send(7, 9, 64'hDEAD_BEEF_CAFE_F00D, 2, 3, 32'h8000_0000);
        send(7, 9, 64'hDEAD_BEEF_CAFE_F00D, 2, 0, 32'h8000_0000);
        // Corners: largest position and address wrap
        send(4095, 4095, 64'hFFFF_FFFF_FFFF_FFFF, 5, 0, 32'hFFFF_FFFC);
        send(4095, 4095, 64'h0, 5, 1, 32'hFFFF_FFF0);
        send(0, 0, 64'h7FFF_0800_07FF_F000, 0, 2, 32'h0);
        // Mixed pattern with gaps
        for (int i = 0; i < 60; i++) begin
            send(int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
                 {$urandom, $urandom}, int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 3)), {$urandom} & 32'hFFFF_FFFC);
            if (i % 7 == 3) idle();
        end
        idle();
        idle();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule